// File: doc/BRIEF.md
# Event Translation Validation Engine

This block carries out the three translate-event commands of a message-based interrupt translator: raise an interrupt, clear it, and clear-and-unmap it. A command names a device and an event. The engine reads that device's entry from the device table. The device entry gives the size and location of the device's event table. The engine then reads the event entry, which yields a collection number and an interrupt number. Last, it reads the collection entry, which names the target CPU. When every check passes, it delivers a one-cycle pending strobe to that CPU with the interrupt number and a set or clear level.

All table traffic uses a single lookup port, one access at a time. A request is held until the memory side acknowledges it, and the acknowledge may carry an error flag. The checks on the command and on the fetched entries run in a fixed order. The first check that fails ends the command quietly with a CONTINUE result. A memory error at any stage ends the command with a STALL result instead. Each command reports exactly one outcome, as a done pulse with a stall flag.

Top module: `etv_engine`

## Requirements
- R1: While reset is high and in the first cycle after it falls, busy, done, done_stall, lk_req and pend_stb are all low.
- R2: A command whose device number is at or above NUM_DEV completes with CONTINUE in the cycle after it is accepted. It issues no lookup and no strobe.
- R3: Lookups are issued in a fixed order: device (kind 0, index = device number), then event (kind 1, base = bits [31:16] of the device entry, index = event number), then collection (kind 2, index = collection number). Each request stays asserted with stable fields until the cycle in which it is acknowledged.
- R4: An acknowledge with the error flag set on the device, event or collection read ends the command with STALL. No further lookup and no strobe follow.
- R5: A device entry whose bit 0 (valid) is clear ends the command with CONTINUE. No event lookup is made.
- R6: The event count of a device is 2 to the power (size + 1), where size is bits [5:1] of the device entry. An event number at or above that count ends the command with CONTINUE before the event lookup.
- R7: An event entry whose bit 0 is clear, or whose collection field (bits [15:1]) is at or above NUM_COLL, ends the command with CONTINUE before the collection lookup.
- R8: A collection entry whose bit 0 is clear, or whose CPU field (bits [15:1]) is at or above NUM_CPU, ends the command with CONTINUE and no strobe.
- R9: When all checks pass, pend_stb is high for exactly one cycle. It carries the CPU from the collection entry and the interrupt number from bits [31:16] of the event entry. pend_set is 1 for op code 0 (raise) and 0 for op codes 1 (clear), 2 (clear-and-unmap) and 3 (handled as clear).
- R10: After its strobe, op code 2 issues a write lookup (lk_write high, kind 1, same base and index as the event read) that stores an all-zero event entry. An error on that write gives STALL; otherwise the result is CONTINUE. The other op codes issue no write.
- R11: Each accepted command gives exactly one done pulse, with done_stall valid in the same cycle. A cmd_start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start a command (accepted when not busy) |
| cmd_op | input | 2 | 0 raise, 1 clear, 2 clear-and-unmap, 3 clear |
| cmd_dev_id | input | DEVID_W | Device number |
| cmd_evt_id | input | EVTID_W | Event number |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| done_stall | output | 1 | With done: 1 = STALL, 0 = CONTINUE |
| lk_req | output | 1 | Lookup request, held until acknowledged |
| lk_kind | output | 2 | Table: 0 device, 1 event, 2 collection |
| lk_write | output | 1 | Request is a write of an all-zero entry |
| lk_index | output | IDX_W | Entry index within the table |
| lk_base | output | 16 | Event table location (event lookups only) |
| lk_ack | input | 1 | Lookup acknowledge, one cycle |
| lk_err | input | 1 | Memory error with the acknowledge |
| lk_rdata | input | 32 | Entry read data with the acknowledge |
| pend_stb | output | 1 | Pending-state update strobe |
| pend_cpu | output | CPU_IDX_W | Target CPU |
| pend_intid | output | 16 | Interrupt number |
| pend_set | output | 1 | 1 set pending, 0 clear pending |

## Verification
The assertions assume that the memory side asserts lk_ack only while lk_req is high, for one cycle per request, and that lk_err and lk_rdata are meaningful only in that cycle. The bench's table responder is built on exactly that rule. It answers a held request after a programmable number of idle cycles and drops its acknowledge on the next cycle, before it looks at any following request. Every scenario is started only when the engine is idle, except the one that deliberately pulses cmd_start during a command to show that the pulse is ignored.

// File: rtl/etv_pkg.sv
package etv_pkg;

  // Entry word layout shared by all three tables
  localparam int ENTRY_W   = 32;
  localparam int VALID_POS = 0;
  localparam int SIZE_LSB  = 1;
  localparam int SIZE_W    = 5;
  localparam int PTR_LSB   = 16;
  localparam int PTR_W     = 16;
  localparam int REF_LSB   = 1;   // collection field (event entry) / CPU field (collection entry)
  localparam int REF_W     = 15;
  localparam int INTID_LSB = 16;
  localparam int INTID_W   = 16;

  typedef enum logic [1:0] {
    TBL_DEV  = 2'd0,
    TBL_EVT  = 2'd1,
    TBL_COLL = 2'd2
  } tbl_e;

  typedef enum logic [1:0] {
    OP_RAISE   = 2'd0,
    OP_CLEAR   = 2'd1,
    OP_UNMAP   = 2'd2,
    OP_CLEAR_X = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_EVT,
    ST_COLL,
    ST_WR
  } st_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/etv_limit.sv
// Unsigned "value below limit" comparator; a limit beyond the field range passes all.
module etv_limit #(
  parameter int W     = 8,
  parameter int LIMIT = 16
) (
  input  logic [W-1:0] value,
  output logic         in_range
);
  localparam longint FULL = longint'(1) << W;
  localparam longint CAP  = (longint'(LIMIT) >= FULL) ? FULL : longint'(LIMIT);
  localparam logic [W:0] LIM = CAP[W:0];

  assign in_range = ({1'b0, value} < LIM);
endmodule

// File: rtl/etv_evt_window.sv
// Event number check against a count of 2**(size+1).
module etv_evt_window #(
  parameter int EVTID_W = 16,
  parameter int SZ_W    = 5
) (
  input  logic [EVTID_W-1:0] evt_id,
  input  logic [SZ_W-1:0]    size_f,
  output logic               in_range
);
  logic [SZ_W:0] shamt;

  assign shamt    = {1'b0, size_f} + {{SZ_W{1'b0}}, 1'b1};
  assign in_range = ((evt_id >> shamt) == '0);
endmodule

// File: rtl/etv_notify.sv
// Registered pending-state strobe toward the target CPU.
module etv_notify #(
  parameter int CPU_IDX_W = 2,
  parameter int ID_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [CPU_IDX_W-1:0] cpu_in,
  input  logic [ID_W-1:0]      intid_in,
  input  logic                 level_in,
  output logic                 stb,
  output logic [CPU_IDX_W-1:0] cpu,
  output logic [ID_W-1:0]      intid,
  output logic                 level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stb   <= 1'b0;
      cpu   <= '0;
      intid <= '0;
      level <= 1'b0;
    end else begin
      stb <= fire;
      if (fire) begin
        cpu   <= cpu_in;
        intid <= intid_in;
        level <= level_in;
      end
    end
  end

  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);
endmodule

// File: rtl/etv_engine.sv
module etv_engine
  import etv_pkg::*;
#(
  parameter int NUM_DEV  = 64,
  parameter int DEVID_W  = 8,
  parameter int EVTID_W  = 16,
  parameter int NUM_COLL = 16,
  parameter int NUM_CPU  = 4,
  localparam int IDX_W     = max3(DEVID_W, EVTID_W, REF_W),
  localparam int CPU_IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_start,
  input  logic [1:0]           cmd_op,
  input  logic [DEVID_W-1:0]   cmd_dev_id,
  input  logic [EVTID_W-1:0]   cmd_evt_id,
  output logic                 busy,
  output logic                 done,
  output logic                 done_stall,
  output logic                 lk_req,
  output logic [1:0]           lk_kind,
  output logic                 lk_write,
  output logic [IDX_W-1:0]     lk_index,
  output logic [PTR_W-1:0]     lk_base,
  input  logic                 lk_ack,
  input  logic                 lk_err,
  input  logic [ENTRY_W-1:0]   lk_rdata,
  output logic                 pend_stb,
  output logic [CPU_IDX_W-1:0] pend_cpu,
  output logic [INTID_W-1:0]   pend_intid,
  output logic                 pend_set
);

  st_e                st;
  op_e                op_q;
  tbl_e               kind_q;
  logic [EVTID_W-1:0] evt_q;
  logic [PTR_W-1:0]   ptr_q;
  logic [INTID_W-1:0] intid_q;

  // Fields of the word returned with an acknowledge
  logic               r_valid;
  logic [SIZE_W-1:0]  r_size;
  logic [PTR_W-1:0]   r_ptr;
  logic [REF_W-1:0]   r_ref;
  logic [INTID_W-1:0] r_intid;

  assign r_valid = lk_rdata[VALID_POS];
  assign r_size  = lk_rdata[SIZE_LSB +: SIZE_W];
  assign r_ptr   = lk_rdata[PTR_LSB +: PTR_W];
  assign r_ref   = lk_rdata[REF_LSB +: REF_W];
  assign r_intid = lk_rdata[INTID_LSB +: INTID_W];

  logic dev_ok, evt_ok, coll_ok, cpu_ok;

  etv_limit #(.W(DEVID_W), .LIMIT(NUM_DEV)) u_dev_lim (
    .value(cmd_dev_id), .in_range(dev_ok));

  etv_evt_window #(.EVTID_W(EVTID_W), .SZ_W(SIZE_W)) u_evt_win (
    .evt_id(evt_q), .size_f(r_size), .in_range(evt_ok));

  etv_limit #(.W(REF_W), .LIMIT(NUM_COLL)) u_coll_lim (
    .value(r_ref), .in_range(coll_ok));

  etv_limit #(.W(REF_W), .LIMIT(NUM_CPU)) u_cpu_lim (
    .value(r_ref), .in_range(cpu_ok));

  // Strobe request: collection entry accepted
  logic fire;
  assign fire = (st == ST_COLL) && lk_ack && !lk_err && r_valid && cpu_ok;

  etv_notify #(.CPU_IDX_W(CPU_IDX_W), .ID_W(INTID_W)) u_notify (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .cpu_in   (CPU_IDX_W'(r_ref)),
    .intid_in (intid_q),
    .level_in (op_q == OP_RAISE),
    .stb      (pend_stb),
    .cpu      (pend_cpu),
    .intid    (pend_intid),
    .level    (pend_set)
  );

  assign busy    = (st != ST_IDLE);
  assign lk_kind = kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      op_q       <= OP_RAISE;
      kind_q     <= TBL_DEV;
      evt_q      <= '0;
      ptr_q      <= '0;
      intid_q    <= '0;
      lk_req     <= 1'b0;
      lk_write   <= 1'b0;
      lk_index   <= '0;
      lk_base    <= '0;
      done       <= 1'b0;
      done_stall <= 1'b0;
    end else begin
      done       <= 1'b0;
      done_stall <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (cmd_start) begin
            op_q  <= op_e'(cmd_op);
            evt_q <= cmd_evt_id;
            if (!dev_ok) begin
              done <= 1'b1;
            end else begin
              st       <= ST_DEV;
              lk_req   <= 1'b1;
              lk_write <= 1'b0;
              kind_q   <= TBL_DEV;
              lk_index <= IDX_W'(cmd_dev_id);
              lk_base  <= '0;
            end
          end
        end
        ST_DEV: begin
          if (lk_ack) begin
            if (lk_err || !r_valid || !evt_ok) begin
              st         <= ST_IDLE;
              lk_req     <= 1'b0;
              done       <= 1'b1;
              done_stall <= lk_err;
            end else begin
              st       <= ST_EVT;
              kind_q   <= TBL_EVT;
              lk_index <= IDX_W'(evt_q);
              lk_base  <= r_ptr;
              ptr_q    <= r_ptr;
            end
          end
        end
        ST_EVT: begin
          if (lk_ack) begin
            if (lk_err || !r_valid || !coll_ok) begin
              st         <= ST_IDLE;
              lk_req     <= 1'b0;
              done       <= 1'b1;
              done_stall <= lk_err;
            end else begin
              st       <= ST_COLL;
              kind_q   <= TBL_COLL;
              lk_index <= IDX_W'(r_ref);
              lk_base  <= '0;
              intid_q  <= r_intid;
            end
          end
        end
        ST_COLL: begin
          if (lk_ack) begin
            if (fire && (op_q == OP_UNMAP)) begin
              st       <= ST_WR;
              kind_q   <= TBL_EVT;
              lk_write <= 1'b1;
              lk_index <= IDX_W'(evt_q);
              lk_base  <= ptr_q;
            end else begin
              st         <= ST_IDLE;
              lk_req     <= 1'b0;
              done       <= 1'b1;
              done_stall <= lk_err;
            end
          end
        end
        ST_WR: begin
          if (lk_ack) begin
            st         <= ST_IDLE;
            lk_req     <= 1'b0;
            lk_write   <= 1'b0;
            done       <= 1'b1;
            done_stall <= lk_err;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !lk_ack) |=> (lk_req && $stable(lk_kind) && $stable(lk_index)
                             && $stable(lk_base) && $stable(lk_write)));

  // R4
  err_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_req && lk_ack && lk_err) |=> (done && done_stall && !lk_req && !pend_stb));

  // R10
  zero_write_chk: assert property (@(posedge clk) disable iff (rst)
    lk_write |-> (lk_kind == TBL_EVT && lk_req));

  // R9
  strobe_place_chk: assert property (@(posedge clk) disable iff (rst)
    pend_stb |-> ((done && !done_stall) || lk_write));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R11
  stall_qual_chk: assert property (@(posedge clk) disable iff (rst)
    done_stall |-> done);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !lk_req);

endmodule

// File: tb/etv_engine_test.sv
`timescale 1ns/100ps
module etv_engine_test;
  localparam int NUM_DEV  = 64;
  localparam int NUM_COLL = 16;
  localparam int NUM_CPU  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [7:0]  cmd_dev_id = '0;
  logic [15:0] cmd_evt_id = '0;
  logic        busy, done, done_stall;
  logic        lk_req, lk_write;
  logic [1:0]  lk_kind;
  logic [15:0] lk_index, lk_base;
  logic        lk_ack = 1'b0, lk_err = 1'b0;
  logic [31:0] lk_rdata = '0;
  logic        pend_stb, pend_set;
  logic [1:0]  pend_cpu;
  logic [15:0] pend_intid;

  always #2.5 clk = ~clk;

  etv_engine #(.NUM_DEV(NUM_DEV), .DEVID_W(8), .EVTID_W(16),
               .NUM_COLL(NUM_COLL), .NUM_CPU(NUM_CPU)) uut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_dev_id(cmd_dev_id), .cmd_evt_id(cmd_evt_id),
    .busy(busy), .done(done), .done_stall(done_stall),
    .lk_req(lk_req), .lk_kind(lk_kind), .lk_write(lk_write),
    .lk_index(lk_index), .lk_base(lk_base),
    .lk_ack(lk_ack), .lk_err(lk_err), .lk_rdata(lk_rdata),
    .pend_stb(pend_stb), .pend_cpu(pend_cpu), .pend_intid(pend_intid),
    .pend_set(pend_set));

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // Table model
  logic [31:0] dev_tab [NUM_DEV];
  logic [31:0] evt_tab [int];
  logic [31:0] col_tab [NUM_COLL];
  int fail_kind = -1;   // 0 dev, 1 event, 2 collection, 3 write
  int lat = 0;
  int wcnt = 0;

  // Per-command log
  int n_rd [3];
  int rd_idx [3];
  int rd_base [3];
  int n_wr, wr_addr, n_stb, n_done;
  int stb_cpu, stb_intid, stb_lvl, got_stall;

  function automatic logic [31:0] mk_dev(bit v, int size, int ptr);
    return (32'(ptr) << 16) | (32'(size) << 1) | 32'(v);
  endfunction
  function automatic logic [31:0] mk_evt(bit v, int coll, int intid);
    return (32'(intid) << 16) | (32'(coll) << 1) | 32'(v);
  endfunction
  function automatic logic [31:0] mk_col(bit v, int cpu);
    return (32'(cpu) << 1) | 32'(v);
  endfunction

  task automatic serve();
    int k, a;
    bit e;
    k = int'(lk_kind);
    a = int'(lk_base) + int'(lk_index);
    if (lk_write) begin
      n_wr++;
      wr_addr = a;
      e = (fail_kind == 3);
      if (!e) evt_tab[a] = 32'd0;
      lk_rdata = 32'd0;
    end else begin
      if (k < 3) begin
        n_rd[k]++;
        rd_idx[k] = int'(lk_index);
        rd_base[k] = int'(lk_base);
      end
      e = (fail_kind == k);
      case (k)
        0: lk_rdata = (lk_index < NUM_DEV) ? dev_tab[lk_index] : 32'd0;
        1: lk_rdata = evt_tab.exists(a) ? evt_tab[a] : 32'd0;
        2: lk_rdata = (lk_index < NUM_COLL) ? col_tab[lk_index] : 32'd0;
        default: lk_rdata = 32'd0;
      endcase
      if (e) lk_rdata = 32'hFFFF_FFFF;
    end
    lk_err = e;
    lk_ack = 1'b1;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (lk_ack) begin
        lk_ack = 1'b0;
        lk_err = 1'b0;
      end else if (lk_req && !rst) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0;
          serve();
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (pend_stb) begin
          n_stb++;
          stb_cpu = int'(pend_cpu);
          stb_intid = int'(pend_intid);
          stb_lvl = int'(pend_set);
        end
        if (done) begin
          n_done++;
          got_stall = int'(done_stall);
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int k = 0; k < 3; k++) begin
      n_rd[k] = 0; rd_idx[k] = -1; rd_base[k] = -1;
    end
    n_wr = 0; wr_addr = -1; n_stb = 0; n_done = 0;
    stb_cpu = -1; stb_intid = -1; stb_lvl = -1; got_stall = -1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 300 && n_done == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_cmd(input int op, input int dev, input int evt);
    clear_log();
    @(negedge clk);
    cmd_start  = 1'b1;
    cmd_op     = 2'(op);
    cmd_dev_id = 8'(dev);
    cmd_evt_id = 16'(evt);
    @(negedge clk);
    cmd_start = 1'b0;
    wait_done();
  endtask

  task automatic base_setup();
    for (int i = 0; i < NUM_DEV; i++) dev_tab[i] = 32'd0;
    for (int i = 0; i < NUM_COLL; i++) col_tab[i] = 32'd0;
    evt_tab.delete();
    dev_tab[3] = mk_dev(1, 3, 16'h100);
    evt_tab[16'h105] = mk_evt(1, 2, 16'h2005);
    col_tab[2] = mk_col(1, 1);
    fail_kind = -1;
    lat = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "done in reset", done, 0);
    chk("R1", "lk_req in reset", lk_req, 0);
    chk("R1", "pend_stb in reset", pend_stb, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done_stall after reset", done_stall, 0);
  endtask

  task automatic t_raise();
    base_setup();
    run_cmd(0, 3, 5);
    chk("R11", "raise done count", n_done, 1);
    chk("R11", "raise stall", got_stall, 0);
    chk("R3", "device index", rd_idx[0], 3);
    chk("R3", "event base", rd_base[1], 16'h100);
    chk("R3", "event index", rd_idx[1], 5);
    chk("R3", "collection index", rd_idx[2], 2);
    chk("R9", "strobe count", n_stb, 1);
    chk("R9", "strobe cpu", stb_cpu, 1);
    chk("R9", "strobe intid", stb_intid, 16'h2005);
    chk("R9", "raise level", stb_lvl, 1);
    chk("R10", "raise writes", n_wr, 0);
  endtask

  task automatic t_clear();
    base_setup();
    run_cmd(1, 3, 5);
    chk("R9", "clear level", stb_lvl, 0);
    chk("R9", "clear strobe count", n_stb, 1);
    chk("R10", "clear writes", n_wr, 0);
    run_cmd(3, 3, 5);
    chk("R9", "op3 level", stb_lvl, 0);
    chk("R10", "op3 writes", n_wr, 0);
  endtask

  task automatic t_unmap();
    base_setup();
    run_cmd(2, 3, 5);
    chk("R9", "unmap level", stb_lvl, 0);
    chk("R10", "unmap write count", n_wr, 1);
    chk("R10", "unmap write address", wr_addr, 16'h105);
    chk("R10", "unmap stall", got_stall, 0);
    chk("R11", "unmap done count", n_done, 1);
    run_cmd(0, 3, 5);
    chk("R10", "raise after unmap strobes", n_stb, 0);
    chk("R7", "zeroed event stops collection read", n_rd[2], 0);
  endtask

  task automatic t_dev_checks();
    base_setup();
    run_cmd(0, NUM_DEV, 0);
    chk("R2", "out-of-range device reads", n_rd[0], 0);
    chk("R2", "out-of-range device done", n_done, 1);
    chk("R2", "out-of-range device stall", got_stall, 0);
    chk("R2", "out-of-range device strobe", n_stb, 0);
    run_cmd(0, NUM_DEV - 1, 0);
    chk("R5", "invalid device read once", n_rd[0], 1);
    chk("R5", "invalid device no event read", n_rd[1], 0);
    chk("R5", "invalid device stall", got_stall, 0);
  endtask

  task automatic t_evt_window();
    base_setup();
    dev_tab[4] = mk_dev(1, 3, 16'h200);
    evt_tab[16'h200 + 15] = mk_evt(1, 2, 16'h0F0F);
    run_cmd(0, 4, 16);
    chk("R6", "size3 event 16 no event read", n_rd[1], 0);
    chk("R6", "size3 event 16 stall", got_stall, 0);
    run_cmd(0, 4, 15);
    chk("R6", "size3 event 15 read", n_rd[1], 1);
    chk("R6", "size3 event 15 strobe", n_stb, 1);
    dev_tab[5] = mk_dev(1, 0, 16'h300);
    run_cmd(0, 5, 2);
    chk("R6", "size0 event 2 no event read", n_rd[1], 0);
    run_cmd(0, 5, 1);
    chk("R6", "size0 event 1 read", n_rd[1], 1);
    dev_tab[6] = mk_dev(1, 31, 16'h400);
    run_cmd(0, 6, 16'hFFFF);
    chk("R6", "size31 max event read", n_rd[1], 1);
  endtask

  task automatic t_evt_checks();
    base_setup();
    evt_tab[16'h100 + 7] = mk_evt(0, 2, 16'h1111);
    run_cmd(0, 3, 7);
    chk("R7", "invalid event no collection read", n_rd[2], 0);
    evt_tab[16'h100 + 8] = mk_evt(1, NUM_COLL, 16'h2222);
    run_cmd(0, 3, 8);
    chk("R7", "collection 16 no collection read", n_rd[2], 0);
    chk("R7", "collection 16 stall", got_stall, 0);
    evt_tab[16'h100 + 9] = mk_evt(1, NUM_COLL - 1, 16'h3333);
    col_tab[NUM_COLL - 1] = mk_col(1, 0);
    run_cmd(0, 3, 9);
    chk("R7", "collection 15 read", n_rd[2], 1);
    chk("R7", "collection 15 strobe intid", stb_intid, 16'h3333);
  endtask

  task automatic t_coll_checks();
    base_setup();
    col_tab[2] = mk_col(0, 1);
    run_cmd(0, 3, 5);
    chk("R8", "invalid collection strobe", n_stb, 0);
    chk("R8", "invalid collection stall", got_stall, 0);
    col_tab[2] = mk_col(1, NUM_CPU);
    run_cmd(0, 3, 5);
    chk("R8", "cpu 4 strobe", n_stb, 0);
    col_tab[2] = mk_col(1, NUM_CPU - 1);
    run_cmd(0, 3, 5);
    chk("R8", "cpu 3 strobe cpu", stb_cpu, NUM_CPU - 1);
  endtask

  task automatic t_errors();
    base_setup();
    fail_kind = 0;
    run_cmd(0, 3, 5);
    chk("R4", "device error stall", got_stall, 1);
    chk("R4", "device error no event read", n_rd[1], 0);
    fail_kind = 1;
    run_cmd(0, 3, 5);
    chk("R4", "event error stall", got_stall, 1);
    chk("R4", "event error no collection read", n_rd[2], 0);
    fail_kind = 2;
    run_cmd(0, 3, 5);
    chk("R4", "collection error stall", got_stall, 1);
    chk("R4", "collection error strobe", n_stb, 0);
    chk("R11", "collection error done count", n_done, 1);
  endtask

  task automatic t_write_error();
    base_setup();
    fail_kind = 3;
    run_cmd(2, 3, 5);
    chk("R10", "write error stall", got_stall, 1);
    chk("R10", "write error strobe still sent", n_stb, 1);
  endtask

  task automatic t_latency();
    base_setup();
    lat = 3;
    run_cmd(0, 3, 5);
    chk("R3", "slow memory strobe intid", stb_intid, 16'h2005);
    chk("R3", "slow memory reads", n_rd[0] + n_rd[1] + n_rd[2], 3);
    chk("R3", "slow memory stall", got_stall, 0);
  endtask

  task automatic t_busy_ignore();
    base_setup();
    lat = 3;
    dev_tab[4] = mk_dev(1, 3, 16'h200);
    evt_tab[16'h200 + 5] = mk_evt(1, 2, 16'h4444);
    clear_log();
    @(negedge clk);
    cmd_start = 1'b1; cmd_op = 2'd0; cmd_dev_id = 8'd3; cmd_evt_id = 16'd5;
    @(negedge clk);
    cmd_dev_id = 8'd4;
    @(negedge clk);
    cmd_start = 1'b0;
    wait_done();
    repeat (40) @(negedge clk);
    chk("R11", "busy start done count", n_done, 1);
    chk("R11", "busy start device reads", n_rd[0], 1);
    chk("R11", "busy start intid", stb_intid, 16'h2005);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_raise();
    t_clear();
    t_unmap();
    t_dev_checks();
    t_evt_window();
    t_evt_checks();
    t_coll_checks();
    t_errors();
    t_write_error();
    t_latency();
    t_busy_ignore();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule